// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches an already synchronized serial receive line and decides when the far end has dropped it into a break. It measures how long the line has been low, counting the 16x oversampling ticks, and compares that with a limit expressed in whole character times. A character time is ten bits, or eleven bits when a parity bit is in use. A 2-bit selector sets the limit to 2, 4, 8 or 16 characters.

When the limit is passed, the block raises a live break level and emits a single one-cycle event pulse. The pulse fires once for each break. The detector re-arms only after the line has been seen high on eight consecutive ticks, which is half a bit time. A receiver or an interrupt controller takes both outputs directly.

Top module: `line_break_det`

## Requirements
- R1: After reset, `break_o` and `break_pulse_o` are 0.
- R2: The limit in ticks is 16 × B × C. B is 10 when `parity_en_i` is 0 and 11 when it is 1. C is 2, 4, 8 or 16 for `level_sel_i` = 0, 1, 2 or 3. A low run of exactly the limit raises nothing.
- R3: `break_pulse_o` is high for exactly one cycle. It rises in the cycle after the tick on which the line has been sampled low for limit+1 consecutive ticks, and `break_o` rises in that same cycle.
- R4: A continuous low run gives only one pulse, however long it lasts, and `break_o` stays 1 throughout.
- R5: While `break_o` is 1, it falls in the cycle after the eighth consecutive high tick. Any low tick before that restarts the high count. No new pulse can occur until `break_o` has fallen.
- R6: A single tick that samples the line high restarts the low-time count from zero.
- R7: The line is sampled only in cycles where `tick_i` is 1. Its value in other cycles has no effect, and neither output changes in the cycle after a cycle without a tick.
- R8: A change of `level_sel_i` is used at the next tick. Without a tick, no pulse results, even if the low time already exceeds the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronized receive line, idle high |
| tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| parity_en_i | input | 1 | 1 when each character carries a parity bit |
| level_sel_i | input | 2 | Break limit select: 2, 4, 8 or 16 characters |
| break_o | output | 1 | Live break status |
| break_pulse_o | output | 1 | One-cycle event per break |

## Verification
Both outputs are registered, so every result is due in the cycle right after the clock edge that sampled the deciding tick. Nothing is delayed further. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and the bench compares both outputs with it at the next falling edge, which is one cycle after the tick. Directed scenarios count the pulses between falling-edge samples. They place runs at exactly the limit and one tick past it, seven and eight high ticks, and a selector change made without a tick. Each run toggles the line in the cycles between ticks.

// File: rtl/line_break_det.sv
module line_break_det #(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       parity_en_i,
  input  logic [1:0] level_sel_i,
  output logic       break_o,
  output logic       break_pulse_o
);
  localparam int HALF_BIT = TICKS_PER_BIT / 2;
  localparam int HC_W     = $clog2(HALF_BIT + 1);

  logic [CNT_W-1:0] low_cnt, char_ticks, limit;
  logic [HC_W-1:0]  high_cnt;
  logic             low_sat, over;

  assign char_ticks = parity_en_i ? CNT_W'(11 * TICKS_PER_BIT) : CNT_W'(10 * TICKS_PER_BIT);
  assign limit      = char_ticks << ({1'b0, level_sel_i} + 3'd1);
  assign low_sat    = &low_cnt;
  assign over       = low_cnt >= limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt       <= '0;
      high_cnt      <= '0;
      break_o       <= 1'b0;
      break_pulse_o <= 1'b0;
    end else begin
      break_pulse_o <= 1'b0;
      if (tick_i) begin
        if (!rx_i) begin
          high_cnt <= '0;
          if (!low_sat) low_cnt <= low_cnt + 1'b1;
          if (!break_o && over) begin
            break_o       <= 1'b1;
            break_pulse_o <= 1'b1;
          end
        end else begin
          low_cnt <= '0;
          if (break_o) begin
            if (high_cnt == HC_W'(HALF_BIT - 1)) begin
              break_o  <= 1'b0;
              high_cnt <= '0;
            end else begin
              high_cnt <= high_cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/line_break_det_chk.sv
module line_break_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic tick_i,
  input logic break_o,
  input logic break_pulse_o
);
  a_r3_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_pulse_o |=> !break_pulse_o);
  a_r3_pulse_with_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_pulse_o |-> break_o);
  a_r4_pulse_only_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_pulse_o |-> !$past(break_o));
  a_r5_clear_on_high_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(break_o) |-> ($past(rx_i) && $past(tick_i)));
  a_r7_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(break_o) && !break_pulse_o));
  a_r6_no_pulse_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rx_i) |=> !break_pulse_o);
endmodule

bind line_break_det line_break_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .tick_i(tick_i),
  .break_o(break_o), .break_pulse_o(break_pulse_o)
);

// File: tb/test_line_break_det.sv
`timescale 1ns/1ps
module test_line_break_det;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0, par = 1'b0;
  logic [1:0] sel = 2'd0;
  logic brk, pulse;

  line_break_det i_line_break_det (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .parity_en_i(par),
    .level_sel_i(sel), .break_o(brk), .break_pulse_o(pulse)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, npulse = 0;
  string req = "R1";
  int m_low = 0, m_high = 0;
  bit m_brk = 0, m_pulse = 0, done = 0;

  function automatic int lim(bit p, logic [1:0] s);
    return (p ? 11 : 10) * 16 * (2 ** (int'(s) + 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_high = 0; m_brk = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (tick) begin
        if (!rx) begin
          m_high = 0;
          if (!m_brk && m_low >= lim(par, sel)) begin m_brk = 1; m_pulse = 1; end
          if (m_low < 4095) m_low++;
        end else begin
          m_low = 0;
          if (m_brk) begin
            m_high++;
            if (m_high >= 8) begin m_brk = 0; m_high = 0; end
          end
        end
      end
    end
  end

  task automatic check(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic step(logic line, logic tk);
    @(negedge clk);
    if (rst_n) begin
      check({req, " break_o"}, brk, m_brk);
      check({req, " break_pulse_o"}, pulse, m_pulse);
      if (pulse) npulse++;
    end
    rx = line; tick = tk;
  endtask

  // each tick is followed by a non-tick cycle with the opposite line level (R7)
  task automatic hold(logic line, int n);
    for (int i = 0; i < n; i++) begin
      step(line, 1'b1);
      step(~line, 1'b0);
    end
  endtask

  int p0;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 break_o", brk, 0);
    check("R1 break_pulse_o", pulse, 0);
    rst_n = 1'b1;
    hold(1'b1, 4);

    req = "R2"; par = 0; sel = 0; p0 = npulse;
    hold(1'b0, 320);
    check("R2 no pulse at exact limit", npulse - p0, 0);
    req = "R6"; hold(1'b1, 1);
    req = "R3"; p0 = npulse;
    hold(1'b0, 321);
    check("R3 one pulse past limit", npulse - p0, 1);
    check("R3 status high", brk, 1);

    req = "R4"; p0 = npulse;
    hold(1'b0, 700);
    check("R4 single pulse per break", npulse - p0, 0);
    check("R4 status held", brk, 1);

    req = "R5";
    hold(1'b1, 7); hold(1'b0, 1);
    check("R5 seven highs keep status", brk, 1);
    hold(1'b1, 7);
    check("R5 restart of high count", brk, 1);
    hold(1'b1, 1);
    check("R5 eighth high clears", brk, 0);

    req = "R2"; par = 1; sel = 1; p0 = npulse;
    hold(1'b0, 704);
    check("R2 parity limit not reached", npulse - p0, 0);
    hold(1'b0, 1);
    check("R2 parity limit passed", npulse - p0, 1);
    hold(1'b1, 8);

    req = "R6"; par = 0; sel = 0; p0 = npulse;
    hold(1'b0, 300); hold(1'b1, 1); hold(1'b0, 300);
    check("R6 high tick restarts count", npulse - p0, 0);
    check("R6 status low", brk, 0);
    hold(1'b1, 8);

    req = "R8"; sel = 1; p0 = npulse;
    hold(1'b0, 400);
    sel = 0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
    check("R8 no pulse without tick", npulse - p0, 0);
    hold(1'b0, 1);
    check("R8 new level at next tick", npulse - p0, 1);
    hold(1'b1, 8);

    req = "R2"; par = 1; sel = 3; p0 = npulse;
    hold(1'b0, 2816);
    check("R2 top limit not reached", npulse - p0, 0);
    hold(1'b0, 1);
    check("R2 top limit passed", npulse - p0, 1);
    req = "R5"; hold(1'b1, 8);
    check("R5 rearmed", brk, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule